// File: doc/BRIEF.md
# Embedded Operation Status Word Generator

This block forms the word a host sees on the data bus while a flash-style memory runs an embedded program or erase operation. An external sequencer supplies the current operation state and a timeout flag. The host address, the address and data being programmed, the sector held by an erase suspend and the array data are also inputs. On every clock the block registers either a status word or the array data unchanged onto its output. The host polls this output to follow progress. It can watch bit 7 turn into the true data bit, watch bits 6 and 2 stop toggling, or see bit 5 report a time limit overrun.

Two toggle flip-flops drive the toggling bits. They change only when a host read completes, which the block detects as a falling edge of the read strobe. They clear whenever a new operation leaves the idle state, so the first status read after a start always returns 0 in both bits. An erase suspend narrows the status to reads of the suspended sector. Every other sector returns array data, or, during a program inside the suspend, a program-style status.

Top module: `opstat_gen`

## Requirements
- R1: With `op_state` = 0 (idle), the output equals the array data presented in the previous cycle.
- R2: With `op_state` = 1 (program), bit 7 reads the complement of `prog_data` bit 7 when `rd_addr` equals `prog_addr`, and reads 0 for any other address.
- R3: With `op_state` = 2 (erase), bit 7 reads 0 and bit 3 reads 1. In program (state 1) and suspend-program (state 4), bit 3 reads 0.
- R4: In states 1, 2 and 4, bit 6 inverts after each completed read, meaning a high-to-low transition of `rd_stb`. It stays unchanged otherwise.
- R5: In states 1, 2 and 4, bit 5 equals the `timeout` input. In state 3 it reads 0.
- R6: In erase (state 2), bit 2 inverts after each completed read at any address. In program (state 1), it reads 1.
- R7: With `op_state` = 3 (erase suspended), a read whose sector matches `susp_sector` returns bit 7 = 1, bit 6 = 1, bit 5 = 0 and bit 3 = 0. Bit 2 inverts after each completed read of that sector. The sector is the top `SECT_W` bits of `rd_addr`.
- R8: With `op_state` = 3, reads outside the suspended sector return the array data unchanged. They leave bit 2 unchanged.
- R9: With `op_state` = 4 (program during erase suspend), a read of `prog_addr` gives bit 2 = 1. A read inside the suspended sector gives a bit 2 that inverts after each completed read there. Any other address gives bit 2 = 1.
- R10: Both toggle bits return to 0 in the cycle after `op_state` leaves 0 for a non-zero value.
- R11: A synchronous active-high `rst` clears the output and both toggle bits.
- R12: In every status word, bits 4, 1 and 0 and all bits above bit 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_state | input | 3 | Operation state: 0 idle, 1 program, 2 erase, 3 erase suspended, 4 suspend-program |
| timeout | input | 1 | Operation has exceeded its time limit |
| rd_stb | input | 1 | Host read strobe; a falling edge ends one read |
| rd_addr | input | ADDR_W | Address of the host read |
| prog_addr | input | ADDR_W | Address being programmed |
| prog_data | input | DATA_W | Data being programmed |
| susp_sector | input | SECT_W | Sector held by the erase suspend |
| array_data | input | DATA_W | Array contents at `rd_addr` |
| dout | output | DATA_W | Registered value for the data bus |

## Verification
The bench builds the block with a 16-bit data width, an 8-bit address and 2 sector bits. The 16-bit width puts bits above bit 7 within reach, so the check that they read 0 in status words and carry array data in pass-through has something to observe. The 2-bit sector field gives four sectors. Reads inside the suspended sector, in a neighbouring sector and at the program address can therefore all be set up in one scenario, and each produces a distinct bit 2 behaviour. Toggle sequences run through several completed reads, and the scenarios restart from idle to show the toggle bits clearing.

// File: rtl/opstat_pkg.sv
package opstat_pkg;

  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_PROG  = 3'd1,
    OP_ERASE = 3'd2,
    OP_ESUSP = 3'd3,
    OP_SPROG = 3'd4
  } op_e;

  localparam int BIT_POLL = 7;
  localparam int BIT_TGL  = 6;
  localparam int BIT_TO   = 5;
  localparam int BIT_ERS  = 3;
  localparam int BIT_SEL  = 2;

endpackage

// File: rtl/opstat_edge.sv
module opstat_edge (
  input  logic clk,
  input  logic rst,
  input  logic stb,
  output logic fall
);
  logic stb_q;

  always_ff @(posedge clk) begin
    if (rst) stb_q <= 1'b0;
    else     stb_q <= stb;
  end

  assign fall = stb_q & ~stb;

  AST_FALL_AFTER_HIGH: assert property (@(posedge clk) disable iff (rst)
    fall |-> $past(stb)); // R4
endmodule

// File: rtl/opstat_toggle.sv
module opstat_toggle (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic flip,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= 1'b0;
    else if (flip)  q <= ~q;
  end

  AST_TGL_CLEARED: assert property (@(posedge clk) disable iff (rst)
    clr |=> !q); // R10
  AST_TGL_FLIPS: assert property (@(posedge clk) disable iff (rst)
    (flip && !clr) |=> q != $past(q)); // R4
  AST_TGL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!flip && !clr) |=> $stable(q)); // R4
endmodule

// File: rtl/opstat_encode.sv
module opstat_encode
  import opstat_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int SECT_W = 2
) (
  input  op_e               op,
  input  logic              timeout,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [DATA_W-1:0] prog_data,
  input  logic [SECT_W-1:0] susp_sector,
  input  logic [DATA_W-1:0] array_data,
  input  logic              t6,
  input  logic              t2,
  output logic              in_susp,
  output logic [DATA_W-1:0] word
);
  logic at_prog;

  assign at_prog = (rd_addr == prog_addr);
  assign in_susp = (rd_addr[ADDR_W-1 -: SECT_W] == susp_sector);

  always_comb begin
    word = '0;
    unique case (op)
      OP_PROG: begin
        word[BIT_POLL] = at_prog ? ~prog_data[BIT_POLL] : 1'b0;
        word[BIT_TGL]  = t6;
        word[BIT_TO]   = timeout;
        word[BIT_ERS]  = 1'b0;
        word[BIT_SEL]  = 1'b1;
      end
      OP_ERASE: begin
        word[BIT_POLL] = 1'b0;
        word[BIT_TGL]  = t6;
        word[BIT_TO]   = timeout;
        word[BIT_ERS]  = 1'b1;
        word[BIT_SEL]  = t2;
      end
      OP_ESUSP: begin
        if (in_susp) begin
          word[BIT_POLL] = 1'b1;
          word[BIT_TGL]  = 1'b1;
          word[BIT_SEL]  = t2;
        end else begin
          word = array_data;
        end
      end
      OP_SPROG: begin
        word[BIT_POLL] = at_prog ? ~prog_data[BIT_POLL] : 1'b0;
        word[BIT_TGL]  = t6;
        word[BIT_TO]   = timeout;
        word[BIT_SEL]  = (!at_prog && in_susp) ? t2 : 1'b1;
      end
      default: word = array_data;
    endcase
  end
endmodule

// File: rtl/opstat_gen.sv
module opstat_gen
  import opstat_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int SECT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        op_state,
  input  logic              timeout,
  input  logic              rd_stb,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [DATA_W-1:0] prog_data,
  input  logic [SECT_W-1:0] susp_sector,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] dout
);
  localparam int N_TGL = 2;

  op_e               op;
  op_e               op_prev;
  logic              rd_fall;
  logic              op_start;
  logic              in_susp;
  logic [N_TGL-1:0]  tgl_q;
  logic [N_TGL-1:0]  tgl_flip;
  logic [DATA_W-1:0] word;

  assign op = op_e'(op_state);

  always_ff @(posedge clk) begin
    if (rst) op_prev <= OP_IDLE;
    else     op_prev <= op;
  end

  assign op_start = (op_prev == OP_IDLE) && (op != OP_IDLE);

  opstat_edge u_edge (
    .clk  (clk),
    .rst  (rst),
    .stb  (rd_stb),
    .fall (rd_fall)
  );

  // index 0: bit 6 toggle, index 1: bit 2 toggle
  assign tgl_flip[0] = rd_fall &&
    (op == OP_PROG || op == OP_ERASE || op == OP_SPROG);
  assign tgl_flip[1] = rd_fall &&
    (op == OP_ERASE || ((op == OP_ESUSP || op == OP_SPROG) && in_susp));

  for (genvar g = 0; g < N_TGL; g++) begin : g_tgl
    opstat_toggle u_tgl (
      .clk  (clk),
      .rst  (rst),
      .clr  (op_start),
      .flip (tgl_flip[g]),
      .q    (tgl_q[g])
    );
  end

  opstat_encode #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .SECT_W (SECT_W)
  ) u_enc (
    .op          (op),
    .timeout     (timeout),
    .rd_addr     (rd_addr),
    .prog_addr   (prog_addr),
    .prog_data   (prog_data),
    .susp_sector (susp_sector),
    .array_data  (array_data),
    .t6          (tgl_q[0]),
    .t2          (tgl_q[1]),
    .in_susp     (in_susp),
    .word        (word)
  );

  always_ff @(posedge clk) begin
    if (rst) dout <= '0;
    else     dout <= word;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (dout == '0)); // R11
  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (rst)
    (op == OP_IDLE) |=> (dout == $past(array_data))); // R1
  AST_ERASE_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (op == OP_ERASE) |=> (!dout[BIT_POLL] && dout[BIT_ERS])); // R3
  AST_TIMEOUT_SHOWN: assert property (@(posedge clk) disable iff (rst)
    (op == OP_PROG || op == OP_ERASE || op == OP_SPROG)
      |=> (dout[BIT_TO] == $past(timeout))); // R5
  AST_SUSP_OTHER_PASS: assert property (@(posedge clk) disable iff (rst)
    (op == OP_ESUSP && !in_susp) |=> (dout == $past(array_data))); // R8
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (op == OP_PROG || op == OP_ERASE)
      |=> (dout[4] == 1'b0 && dout[1:0] == 2'b00)); // R12
endmodule

// File: tb/opstat_gen_tb.sv
module opstat_gen_tb_top;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int SECT_W = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [2:0]        op_state = 3'd0;
  logic              timeout = 1'b0;
  logic              rd_stb = 1'b0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [ADDR_W-1:0] prog_addr = '0;
  logic [DATA_W-1:0] prog_data = '0;
  logic [SECT_W-1:0] susp_sector = '0;
  logic [DATA_W-1:0] array_data = '0;
  logic [DATA_W-1:0] dout;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit m6 = 0;
  bit m2 = 0;

  always #2 clk = ~clk;

  opstat_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W)) dut_i (
    .clk(clk), .rst(rst), .op_state(op_state), .timeout(timeout),
    .rd_stb(rd_stb), .rd_addr(rd_addr), .prog_addr(prog_addr),
    .prog_data(prog_data), .susp_sector(susp_sector),
    .array_data(array_data), .dout(dout)
  );

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [DATA_W-1:0] act,
                     input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit in_sect(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: SECT_W] == susp_sector;
  endfunction

  // Expected word, built from the requirements
  function automatic logic [DATA_W-1:0] model(input logic [ADDR_W-1:0] a);
    logic [DATA_W-1:0] w = '0;
    case (op_state)
      3'd1: begin
        w[7] = (a == prog_addr) ? ~prog_data[7] : 1'b0;
        w[6] = m6; w[5] = timeout; w[2] = 1'b1;
      end
      3'd2: begin
        w[6] = m6; w[5] = timeout; w[3] = 1'b1; w[2] = m2;
      end
      3'd3: begin
        if (in_sect(a)) begin w[7] = 1'b1; w[6] = 1'b1; w[2] = m2; end
        else w = array_data;
      end
      3'd4: begin
        w[7] = (a == prog_addr) ? ~prog_data[7] : 1'b0;
        w[6] = m6; w[5] = timeout;
        w[2] = (a != prog_addr && in_sect(a)) ? m2 : 1'b1;
      end
      default: w = array_data;
    endcase
    return w;
  endfunction

  // One host read: raise strobe, sample, drop strobe, update model toggles
  task automatic host_read(input string req, input logic [ADDR_W-1:0] a);
    rd_addr = a;
    rd_stb  = 1'b1;
    cyc(1);
    chk(req, dout, model(a));
    rd_stb = 1'b0;
    if (op_state == 3'd1 || op_state == 3'd2 || op_state == 3'd4) m6 = ~m6;
    if (op_state == 3'd2 ||
        ((op_state == 3'd3 || op_state == 3'd4) && in_sect(a))) m2 = ~m2;
    cyc(2);
  endtask

  task automatic set_op(input logic [2:0] s);
    if (op_state == 3'd0 && s != 3'd0) begin m6 = 0; m2 = 0; end
    op_state = s;
    cyc(2);
  endtask

  task automatic t_reset;
    array_data = 16'hBEEF;
    rst = 1'b1;
    cyc(3);
    chk("R11 reset output", dout, '0);
    rst = 1'b0;
    cyc(2);
  endtask

  task automatic t_idle;
    set_op(3'd0);
    array_data = 16'hA55A;
    host_read("R1 idle pass", 8'h12);
    array_data = 16'h0081;
    host_read("R1 idle pass 2", 8'hF0);
  endtask

  task automatic t_program;
    prog_addr = 8'h44;
    prog_data = 16'h0080;
    array_data = 16'hFFFF;
    set_op(3'd1);
    host_read("R10 first read toggles zero, R2 complement", 8'h44);
    host_read("R4 bit6 toggled", 8'h44);
    host_read("R2 other address bit7 zero, R6 bit2 one", 8'h10);
    prog_data = 16'h0000;
    host_read("R2 complement of zero bit", 8'h44);
    timeout = 1'b1;
    host_read("R5 timeout in program, R12 unused zero", 8'h44);
    timeout = 1'b0;
    set_op(3'd0);
  endtask

  task automatic t_erase;
    array_data = 16'hFFFF;
    set_op(3'd2);
    for (int i = 0; i < 4; i++) host_read("R3 R6 R4 erase status", 8'h30 + 8'(i));
    timeout = 1'b1;
    host_read("R5 timeout in erase", 8'h01);
    timeout = 1'b0;
    set_op(3'd0);
  endtask

  task automatic t_suspend;
    array_data = 16'h00FF;
    set_op(3'd2);
    host_read("R6 erase before suspend", 8'h80);
    susp_sector = 2'b10;
    timeout = 1'b1;
    set_op(3'd3);
    host_read("R7 suspended sector, R5 bit5 zero", 8'h85);
    host_read("R7 bit2 toggle", 8'h9A);
    array_data = 16'h1234;
    host_read("R8 other sector data", 8'h05);
    array_data = 16'hC3C3;
    host_read("R8 other sector leaves bit2", 8'hC0);
    host_read("R7 bit2 after other-sector read", 8'h81);
    timeout = 1'b0;
  endtask

  task automatic t_susp_prog;
    prog_addr = 8'h22;
    prog_data = 16'h00FF;
    set_op(3'd4);
    host_read("R9 program byte bit2 one, R3 bit3 zero", 8'h22);
    host_read("R9 suspended sector toggles bit2", 8'h88);
    host_read("R9 suspended sector toggles again", 8'h88);
    host_read("R9 other address bit2 one", 8'hC4);
    set_op(3'd0);
  endtask

  task automatic t_restart;
    set_op(3'd2);
    host_read("R4 erase read a", 8'h00);
    set_op(3'd0);
    set_op(3'd2);
    host_read("R10 toggles cleared on restart", 8'h00);
    set_op(3'd0);
  endtask

  initial begin
    cyc(1);
    t_reset();
    t_idle();
    t_program();
    t_erase();
    t_suspend();
    t_susp_prog();
    t_restart();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule